// File: doc/BRIEF.md
# Interrupt Aggregation Status Register

This block is one 32-bit control and status word. It merges several interrupt and wakeup sources into a single active-low interrupt line and a separate wakeup path. The sources are two general-purpose input pins, the interrupt and wakeup lines of a serial port, and a validated power-down request. Each pin has an invert control that forms its internal state. Each pin also has a two-bit level code that selects which internal level counts as active, or turns the pin interrupt off.

Software sets per-source enable bits by writing the word. Reading the word returns live copies of the pin states and of the serial-port interrupt. It also returns a sticky power-down flag, which the read clears. The block drives three outputs: the combined interrupt, a one-cycle pulse that sets an external wakeup-status bit, and an enable that lets the serial port send power-down requests to the downstream filter.

Top module: `irq_agg_csr`

## Requirements
- R1: After reset, all enable bits and the power-down flag are 0, irq_no is 1, wake_set_o is 0 and pd_filt_en_o is 0.
- R2: Read bits 2 and 3 show the internal state of pins 0 and 1. Internal state is gpin_i XOR gpin_inv_i.
- R3: Writable bits 18, 19, 21, 23, 24 and 25 read back the last value written. Bits 1:0, 17:4 and 31:26 read 0 and ignore writes. reg_rdata_o is 0 unless reg_sel_i and reg_rd_i are both high.
- R4: Pin n is an active source when its enable bit is set (bit 18 for pin 0, bit 19 for pin 1) and its level code matches its internal state. The level code is gpin_pol_i[1:0] for pin 0 and gpin_pol_i[3:2] for pin 1. Code 00 means active when the state is 1. Code 01 means active when the state is 0. Codes 10 and 11 never activate the pin.
- R5: When pd_req_i is high on a clock edge, read bit 20 is set after that edge. It stays set until it is cleared by a read.
- R6: A read clears bit 20 at the read edge. If pd_req_i is high on that same edge, bit 20 stays set.
- R7: The power-down flag is an active source only while bit 21 is set.
- R8: Read bit 22 is a live copy of uart_irq_i. The serial-port interrupt is an active source only while bit 23 is set.
- R9: irq_no is registered. It is 0 in the cycle after any active source is present, and 1 otherwise.
- R10: When uart_wake_i rises while bit 24 is set, wake_set_o is high for exactly one cycle after the next edge. No pulse is produced while bit 24 is clear.
- R11: pd_filt_en_o equals bit 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Address decode hit for this word |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (clears the power-down flag) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, zero when not reading |
| gpin_i | input | 2 | General-purpose pin levels |
| gpin_inv_i | input | 2 | Per-pin invert for internal state |
| gpin_pol_i | input | 4 | Per-pin level code, two bits per pin |
| uart_irq_i | input | 1 | Serial-port interrupt |
| uart_wake_i | input | 1 | Serial-port wakeup event line |
| pd_req_i | input | 1 | Validated power-down request |
| irq_no | output | 1 | Combined interrupt, active low |
| wake_set_o | output | 1 | Wakeup-status set pulse |
| pd_filt_en_o | output | 1 | Power-down filter request enable |

## Verification
The assertions assume that every source input is already synchronous to clk_i. They also assume that reg_rd_i is meaningful only together with reg_sel_i, so a clear happens only on a qualified read. The bench changes pins, level codes, invert controls and request lines only at the falling edge. It holds each pattern for at least two edges before sampling, so the registered interrupt has settled. One directed case drives a power-down request and a read on the same edge, to cover the set-versus-clear priority.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned NUM_PINS    = 2;
  localparam int unsigned POL_W       = 2;
  localparam int unsigned ST_LSB      = 2;
  localparam int unsigned PIN_EN_LSB  = 18;
  localparam int unsigned PD_FLAG_BIT = 20;
  localparam int unsigned PD_EN_BIT   = 21;
  localparam int unsigned UIRQ_BIT    = 22;
  localparam int unsigned UIRQ_EN_BIT = 23;
  localparam int unsigned WAKE_EN_BIT = 24;
  localparam int unsigned PDF_EN_BIT  = 25;
  localparam logic [REG_W-1:0] RSVD_MASK = 32'hFC03_FFF3;

  typedef enum logic [POL_W-1:0] {
    POL_HIGH = 2'b00,
    POL_LOW  = 2'b01,
    POL_OFFA = 2'b10,
    POL_OFFB = 2'b11
  } pol_e;

  typedef struct packed {
    logic                pdf_en;
    logic                wake_en;
    logic                uirq_en;
    logic                pd_en;
    logic [NUM_PINS-1:0] pin_en;
  } ctl_t;
endpackage

// File: rtl/gpin_qual.sv
module gpin_qual
  import irq_agg_pkg::*;
#(
  parameter int unsigned N = NUM_PINS
) (
  input  logic [N-1:0]       pin_i,
  input  logic [N-1:0]       inv_i,
  input  logic [N*POL_W-1:0] pol_i,
  input  logic [N-1:0]       en_i,
  output logic [N-1:0]       state_o,
  output logic               act_o
);
  logic [N-1:0] act;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic st;
    assign st         = pin_i[g] ^ inv_i[g];
    assign state_o[g] = st;
    always_comb begin
      unique case (pol_e'(pol_i[g*POL_W +: POL_W]))
        POL_HIGH: act[g] = en_i[g] & st;
        POL_LOW:  act[g] = en_i[g] & ~st;
        default:  act[g] = 1'b0;
      endcase
    end
  end

  assign act_o = |act;
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import irq_agg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  ctl_t wdata_i,
  output ctl_t ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_o <= '0;
    else if (wr_i) ctl_o <= wdata_i;
  end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over clear so a request landing on the clearing read is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/edge_pulse.sv
module edge_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic pulse_o
);
  logic in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q    <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      in_q    <= in_i;
      pulse_o <= in_i & ~in_q;
    end
  end
endmodule

// File: rtl/irq_agg_csr.sv
module irq_agg_csr
  import irq_agg_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_sel_i,
  input  logic                      reg_wr_i,
  input  logic                      reg_rd_i,
  input  logic [REG_W-1:0]          reg_wdata_i,
  output logic [REG_W-1:0]          reg_rdata_o,
  input  logic [NUM_PINS-1:0]       gpin_i,
  input  logic [NUM_PINS-1:0]       gpin_inv_i,
  input  logic [NUM_PINS*POL_W-1:0] gpin_pol_i,
  input  logic                      uart_irq_i,
  input  logic                      uart_wake_i,
  input  logic                      pd_req_i,
  output logic                      irq_no,
  output logic                      wake_set_o,
  output logic                      pd_filt_en_o
);
  logic                wr_en, rd_en;
  ctl_t                ctl, ctl_wr;
  logic                pd_flag;
  logic [NUM_PINS-1:0] pin_state;
  logic                pin_act;
  logic                any_act;
  logic [REG_W-1:0]    word;
  logic                unused_wdata;

  assign wr_en = reg_sel_i & reg_wr_i;
  assign rd_en = reg_sel_i & reg_rd_i;

  assign ctl_wr.pin_en  = reg_wdata_i[PIN_EN_LSB +: NUM_PINS];
  assign ctl_wr.pd_en   = reg_wdata_i[PD_EN_BIT];
  assign ctl_wr.uirq_en = reg_wdata_i[UIRQ_EN_BIT];
  assign ctl_wr.wake_en = reg_wdata_i[WAKE_EN_BIT];
  assign ctl_wr.pdf_en  = reg_wdata_i[PDF_EN_BIT];
  assign unused_wdata   = ^reg_wdata_i;

  ctl_regs u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en),
    .wdata_i(ctl_wr),
    .ctl_o  (ctl)
  );

  gpin_qual #(.N(NUM_PINS)) u_gpin (
    .pin_i  (gpin_i),
    .inv_i  (gpin_inv_i),
    .pol_i  (gpin_pol_i),
    .en_i   (ctl.pin_en),
    .state_o(pin_state),
    .act_o  (pin_act)
  );

  sticky_flag u_pd_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (pd_req_i),
    .clr_i (rd_en),
    .flag_o(pd_flag)
  );

  edge_pulse u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (uart_wake_i & ctl.wake_en),
    .pulse_o(wake_set_o)
  );

  assign any_act = pin_act | (pd_flag & ctl.pd_en) | (uart_irq_i & ctl.uirq_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~any_act;
  end

  always_comb begin
    word                             = '0;
    word[ST_LSB +: NUM_PINS]         = pin_state;
    word[PIN_EN_LSB +: NUM_PINS]     = ctl.pin_en;
    word[PD_FLAG_BIT]                = pd_flag;
    word[PD_EN_BIT]                  = ctl.pd_en;
    word[UIRQ_BIT]                   = uart_irq_i;
    word[UIRQ_EN_BIT]                = ctl.uirq_en;
    word[WAKE_EN_BIT]                = ctl.wake_en;
    word[PDF_EN_BIT]                 = ctl.pdf_en;
  end

  assign reg_rdata_o  = rd_en ? word : '0;
  assign pd_filt_en_o = ctl.pdf_en;
endmodule

// File: rtl/irq_agg_csr_chk.sv
module irq_agg_csr_chk
  import irq_agg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic             pd_req_i,
  input logic             pd_flag_i,
  input logic             wake_en_i,
  input logic             uart_irq_i,
  input logic [REG_W-1:0] rdata_i,
  input logic             wake_set_i
);
  // R5
  pd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_req_i |=> pd_flag_i);
  // R6
  pd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !pd_req_i) |=> !pd_flag_i);
  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i & RSVD_MASK) == '0);
  // R8
  uirq_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> (rdata_i[UIRQ_BIT] == uart_irq_i));
  // R10
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_set_i |=> !wake_set_i);
  // R10
  wake_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_en_i |=> !wake_set_i);
endmodule

bind irq_agg_csr irq_agg_csr_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_en_i   (rd_en),
  .pd_req_i  (pd_req_i),
  .pd_flag_i (pd_flag),
  .wake_en_i (ctl.wake_en),
  .uart_irq_i(uart_irq_i),
  .rdata_i   (reg_rdata_o),
  .wake_set_i(wake_set_o)
);

// File: tb/irq_agg_csr_tb.sv
module irq_agg_csr_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_sel_i = 1'b0, reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [1:0]  gpin_i = '0, gpin_inv_i = '0;
  logic [3:0]  gpin_pol_i = '0;
  logic        uart_irq_i = 1'b0, uart_wake_i = 1'b0, pd_req_i = 1'b0;
  logic        irq_no, wake_set_o, pd_filt_en_o;

  int n_chk = 0, n_fail = 0, n_pulse = 0;
  logic [31:0] rd;

  always #2 clk_i = ~clk_i;

  irq_agg_csr u_dut (.*);

  always @(posedge clk_i) if (wake_set_o) n_pulse++;

  // pin, inv, pol, uart_irq, en{uart,pin1,pin0}, exp_active, exp_state
  typedef struct packed {
    logic [1:0] pin; logic [1:0] inv; logic [3:0] pol; logic uirq;
    logic [2:0] en; logic act; logic [1:0] st;
  } vec_t;
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 2'b00, 4'b0000, 1'b0, 3'b001, 1'b1, 2'b01},
    '{2'b01, 2'b00, 4'b0000, 1'b0, 3'b010, 1'b0, 2'b01},
    '{2'b00, 2'b00, 4'b0001, 1'b0, 3'b001, 1'b1, 2'b00},
    '{2'b00, 2'b01, 4'b0001, 1'b0, 3'b001, 1'b0, 2'b01},
    '{2'b10, 2'b00, 4'b0000, 1'b0, 3'b010, 1'b1, 2'b10},
    '{2'b10, 2'b10, 4'b0000, 1'b0, 3'b010, 1'b0, 2'b00},
    '{2'b11, 2'b00, 4'b1010, 1'b0, 3'b011, 1'b0, 2'b11},
    '{2'b11, 2'b00, 4'b1111, 1'b0, 3'b011, 1'b0, 2'b11},
    '{2'b00, 2'b00, 4'b0100, 1'b0, 3'b010, 1'b1, 2'b00},
    '{2'b00, 2'b00, 4'b0000, 1'b1, 3'b100, 1'b1, 2'b00},
    '{2'b00, 2'b00, 4'b0000, 1'b1, 3'b000, 1'b0, 2'b00},
    '{2'b01, 2'b00, 4'b0000, 1'b0, 3'b000, 1'b0, 2'b01},
    '{2'b11, 2'b11, 4'b0101, 1'b0, 3'b011, 1'b1, 2'b00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i); reg_sel_i = 1; reg_wr_i = 1; reg_wdata_i = d;
    @(negedge clk_i); reg_sel_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  task automatic rdreg(output logic [31:0] d);
    @(negedge clk_i); reg_sel_i = 1; reg_rd_i = 1;
    #1 d = reg_rdata_o;
    @(negedge clk_i); reg_sel_i = 0; reg_rd_i = 0;
  endtask

  task automatic pd_pulse();
    @(negedge clk_i); pd_req_i = 1;
    @(negedge clk_i); pd_req_i = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 irq_no", {31'b0, irq_no}, 32'd1);
    check("R1 wake_set", {31'b0, wake_set_o}, 32'd0);
    check("R1 pd_filt_en", {31'b0, pd_filt_en_o}, 32'd0);
    rst_ni = 1;
    rdreg(rd);
    check("R1 word", rd, 32'h0);
    // R3 idle read data
    #1 check("R3 idle rdata", reg_rdata_o, 32'h0);

    // vector walk: R2 R4 R8 R9
    for (int i = 0; i < NV; i++) begin
      wr({8'h0, VECS[i].en[2], 3'b0, VECS[i].en[1:0], 18'h0});
      gpin_i = VECS[i].pin; gpin_inv_i = VECS[i].inv;
      gpin_pol_i = VECS[i].pol; uart_irq_i = VECS[i].uirq;
      repeat (2) @(negedge clk_i);
      check($sformatf("R4 R9 vec%0d irq_no", i), {31'b0, irq_no}, {31'b0, ~VECS[i].act});
      rdreg(rd);
      check($sformatf("R2 vec%0d state", i), {30'b0, rd[3:2]}, {30'b0, VECS[i].st});
      check($sformatf("R8 vec%0d live", i), {31'b0, rd[22]}, {31'b0, VECS[i].uirq});
    end
    gpin_i = 0; gpin_inv_i = 0; gpin_pol_i = 0; uart_irq_i = 0;

    // R3 R11 writable bits, reserved ignored
    wr(32'hFFFF_FFFF);
    rdreg(rd);
    check("R3 readback", rd, 32'h03AC_0000);
    check("R11 filt en on", {31'b0, pd_filt_en_o}, 32'd1);
    wr(32'h0);
    rdreg(rd);
    check("R3 cleared", rd, 32'h0);
    check("R11 filt en off", {31'b0, pd_filt_en_o}, 32'd0);

    // R5 R7 sticky flag without enable
    pd_pulse();
    repeat (2) @(negedge clk_i);
    check("R7 masked irq_no", {31'b0, irq_no}, 32'd1);
    rdreg(rd);
    check("R5 flag set", {31'b0, rd[20]}, 32'd1);
    rdreg(rd);
    check("R6 flag cleared", {31'b0, rd[20]}, 32'd0);

    // R7 enabled
    wr(32'h0020_0000);
    pd_pulse();
    repeat (2) @(negedge clk_i);
    check("R7 enabled irq_no", {31'b0, irq_no}, 32'd0);
    rdreg(rd);
    repeat (2) @(negedge clk_i);
    check("R6 R9 irq released", {31'b0, irq_no}, 32'd1);

    // R6 request on clearing read
    pd_pulse();
    @(negedge clk_i); reg_sel_i = 1; reg_rd_i = 1; pd_req_i = 1;
    @(negedge clk_i); reg_sel_i = 0; reg_rd_i = 0; pd_req_i = 0;
    rdreg(rd);
    check("R6 set beats clear", {31'b0, rd[20]}, 32'd1);
    rdreg(rd);
    check("R6 then cleared", {31'b0, rd[20]}, 32'd0);
    wr(32'h0);

    // R10 wake pulse
    wr(32'h0100_0000);
    n_pulse = 0;
    @(negedge clk_i); uart_wake_i = 1;
    repeat (5) @(negedge clk_i);
    uart_wake_i = 0;
    repeat (2) @(negedge clk_i);
    check("R10 one pulse", n_pulse, 32'd1);
    wr(32'h0);
    n_pulse = 0;
    @(negedge clk_i); uart_wake_i = 1;
    repeat (5) @(negedge clk_i);
    uart_wake_i = 0;
    repeat (2) @(negedge clk_i);
    check("R10 gated off", n_pulse, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule